// File: doc/BRIEF.md
# Cross-Domain Mailbox and Doorbell Register Block

This block sits between two processor domains, called side A and side B, and gives them a small set of registers for talking to each other. Each side reaches the block through its own simple register bus, with a write strobe, a read strobe, a word address, write data and registered read data. Data written on one side shows up on the other side. The block also raises an interrupt on the side that receives the data.

Each side has four outbound message words, and each of them is mirrored into the matching inbound word on the far side. Writing an outbound message word also latches a sticky status bit on the far side. Each side also has a 32-bit outbound doorbell. The bits written to it are OR-ed into the far side's inbound doorbell, which software clears by writing 1s. A summary bit in the interrupt status register is high while any inbound doorbell bit is set. A mask register selects which status bits drive the side's interrupt line. Two scratchpad words are a single store shared by both sides and raise no interrupt.

Software passes a 16-byte message unit with a two-doorbell handshake built on these registers:
1. The sender writes its four outbound message words.
2. The sender rings doorbell bit 0.
3. The receiver reads its four inbound words.
4. The receiver rings doorbell bit 1 back to acknowledge.

Top module: `xdom_mailbox`

## Requirements
- R1: After a synchronous reset, all registers read zero and both interrupt outputs are low.
- R2: Word addresses 0..3 are the side's outbound message registers. They are read/write, and a read returns the last value written.
- R3: A write to outbound message n on one side loads the value into inbound message n (address 4+n) on the other side. It also sets bit n of the other side's interrupt status register (address 10).
- R4: Inbound message registers (addresses 4..7) are read-only. A write to them changes nothing.
- R5: A write to the outbound doorbell (address 8) ORs the written value into the far side's inbound doorbell (address 9). A read of address 8 returns the last value written there.
- R6: Writing 1s to the inbound doorbell (address 9) clears those bits. Bits written as 0 keep their value.
- R7: Interrupt status bit 4 reads 1 exactly while any inbound doorbell bit is set, and writes to bit 4 have no effect.
- R8: Interrupt status bits 3..0 are sticky and are cleared by writing 1 to them.
- R9: The interrupt mask (address 11, bits 4..0, 1 = masked) is read/write. The interrupt output is the OR of the status bits that are not masked, and it changes on the same clock edge as the status.
- R10: Scratchpads (addresses 12 and 13) are shared. A write from either side is read back by both sides, and it sets no status bit.
- R11: When both sides write the same scratchpad in the same cycle, the value written by side A is kept.
- R12: When a set from the far side and a write-1-to-clear from the local side hit the same doorbell bit or the same message status bit in one cycle, the bit ends up set.
- R13: In the message handshake, the sender writes four words and rings doorbell bit 0. The receiver then sees the whole unit and an interrupt. The receiver's acknowledge on doorbell bit 1 interrupts the sender.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe |
| a_addr | input | AW | Side A word address |
| a_wdata | input | DW | Side A write data |
| a_rdata | output | DW | Side A read data, registered |
| a_irq | output | 1 | Side A interrupt |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_addr | input | AW | Side B word address |
| b_wdata | input | DW | Side B write data |
| b_rdata | output | DW | Side B read data, registered |
| b_irq | output | 1 | Side B interrupt |

## Verification
A write takes effect on the clock edge that samples it. The far side's inbound registers, its status bits and both interrupt outputs all update on that same edge, so the bench samples them at the falling edge that follows. Read data is captured on the edge that samples the read strobe and holds the state from before that edge. Each read check therefore samples one full cycle after the strobe is driven. Simultaneous events (scratchpad collisions, set against clear) are driven in one shared cycle. They are checked through normal reads afterwards.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {
    K_OBM  = 3'd0,
    K_IBM  = 3'd1,
    K_ODB  = 3'd2,
    K_IDB  = 3'd3,
    K_STS  = 3'd4,
    K_MSK  = 3'd5,
    K_SCR  = 3'd6,
    K_NONE = 3'd7
  } reg_kind_e;

  function automatic int idx_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m > 1) ? $clog2(m) : 1;
  endfunction
endpackage

// File: rtl/mbx_addr_decode.sv
module mbx_addr_decode
  import mbx_pkg::*;
#(
  parameter int AW    = 4,
  parameter int NMSG  = 4,
  parameter int NSCR  = 2,
  localparam int IDXW = idx_width(NMSG, NSCR)
) (
  input  logic [AW-1:0]   addr,
  output reg_kind_e       kind,
  output logic [IDXW-1:0] idx
);
  localparam int IBM_B = NMSG;
  localparam int ODB_A = 2 * NMSG;
  localparam int IDB_A = ODB_A + 1;
  localparam int STS_A = ODB_A + 2;
  localparam int MSK_A = ODB_A + 3;
  localparam int SCR_B = ODB_A + 4;

  logic [AW-1:0] off_ibm;
  logic [AW-1:0] off_scr;

  assign off_ibm = addr - AW'(IBM_B);
  assign off_scr = addr - AW'(SCR_B);

  always_comb begin
    kind = K_NONE;
    idx  = '0;
    if (addr < AW'(NMSG)) begin
      kind = K_OBM;
      idx  = IDXW'(addr);
    end else if (addr < AW'(ODB_A)) begin
      kind = K_IBM;
      idx  = IDXW'(off_ibm);
    end else if (addr == AW'(ODB_A)) begin
      kind = K_ODB;
    end else if (addr == AW'(IDB_A)) begin
      kind = K_IDB;
    end else if (addr == AW'(STS_A)) begin
      kind = K_STS;
    end else if (addr == AW'(MSK_A)) begin
      kind = K_MSK;
    end else if (addr < AW'(SCR_B + NSCR)) begin
      kind = K_SCR;
      idx  = IDXW'(off_scr);
    end
  end
endmodule

// File: rtl/mbx_scratch.sv
module mbx_scratch #(
  parameter int DW   = 32,
  parameter int NSCR = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSCR-1:0]    a_wr,
  input  logic [NSCR-1:0]    b_wr,
  input  logic [DW-1:0]      a_data,
  input  logic [DW-1:0]      b_data,
  output logic [NSCR*DW-1:0] scr_flat
);
  for (genvar i = 0; i < NSCR; i++) begin : g_scr
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (a_wr[i]) begin
        word_q <= a_data;
      end else if (b_wr[i]) begin
        word_q <= b_data;
      end
    end
    assign scr_flat[i*DW +: DW] = word_q;
  end
endmodule

// File: rtl/mbx_side_regs.sv
module mbx_side_regs
  import mbx_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int NMSG  = 4,
  parameter int NSCR  = 2,
  localparam int STW  = NMSG + 1,
  localparam int IDXW = idx_width(NMSG, NSCR)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic               irq,
  input  logic [NMSG-1:0]    peer_msg_wr,
  input  logic [DW-1:0]      peer_msg_data,
  input  logic [DW-1:0]      peer_db_set,
  output logic [NMSG-1:0]    msg_wr_o,
  output logic [DW-1:0]      db_set_o,
  output logic [NSCR-1:0]    scr_wr_o,
  input  logic [NSCR*DW-1:0] scr_flat,
  output logic [STW-1:0]     status_o,
  output logic [STW-1:0]     mask_o,
  output logic [DW-1:0]      indb_o
);
  reg_kind_e       kind;
  logic [IDXW-1:0] idx;

  mbx_addr_decode #(.AW(AW), .NMSG(NMSG), .NSCR(NSCR)) u_dec (
    .addr (addr),
    .kind (kind),
    .idx  (idx)
  );

  logic [DW-1:0]   obm_q  [NMSG];
  logic [DW-1:0]   ibm_q  [NMSG];
  logic [DW-1:0]   odb_q;
  logic [DW-1:0]   idb_q, idb_nxt;
  logic [NMSG-1:0] mst_q, mst_nxt;
  logic [STW-1:0]  msk_q, msk_nxt;
  logic [STW-1:0]  sts_nxt;
  logic [DW-1:0]   rd_mux;

  logic wr_obm, wr_odb, wr_idb, wr_sts, wr_msk, wr_scr;
  assign wr_obm = wr_en && (kind == K_OBM);
  assign wr_odb = wr_en && (kind == K_ODB);
  assign wr_idb = wr_en && (kind == K_IDB);
  assign wr_sts = wr_en && (kind == K_STS);
  assign wr_msk = wr_en && (kind == K_MSK);
  assign wr_scr = wr_en && (kind == K_SCR);

  for (genvar n = 0; n < NMSG; n++) begin : g_mwr
    assign msg_wr_o[n] = wr_obm && (idx == IDXW'(n));
  end
  for (genvar s = 0; s < NSCR; s++) begin : g_swr
    assign scr_wr_o[s] = wr_scr && (idx == IDXW'(s));
  end
  assign db_set_o = wr_odb ? wdata : '0;

  // Far-side sets are applied after local clears: a collision leaves the bit set.
  always_comb begin
    idb_nxt = (idb_q & ~(wr_idb ? wdata : '0)) | peer_db_set;
    mst_nxt = (mst_q & ~(wr_sts ? wdata[NMSG-1:0] : '0)) | peer_msg_wr;
    msk_nxt = wr_msk ? wdata[STW-1:0] : msk_q;
    sts_nxt = {|idb_nxt, mst_nxt};
  end

  always_ff @(posedge clk) begin
    for (int n = 0; n < NMSG; n++) begin
      if (rst) begin
        obm_q[n] <= '0;
        ibm_q[n] <= '0;
      end else begin
        if (msg_wr_o[n])    obm_q[n] <= wdata;
        if (peer_msg_wr[n]) ibm_q[n] <= peer_msg_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      odb_q <= '0;
      idb_q <= '0;
      mst_q <= '0;
      msk_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (wr_odb) odb_q <= wdata;
      idb_q <= idb_nxt;
      mst_q <= mst_nxt;
      msk_q <= msk_nxt;
      irq   <= |(sts_nxt & ~msk_nxt);
    end
  end

  always_comb begin
    rd_mux = '0;
    case (kind)
      K_OBM:   rd_mux = obm_q[idx];
      K_IBM:   rd_mux = ibm_q[idx];
      K_ODB:   rd_mux = odb_q;
      K_IDB:   rd_mux = idb_q;
      K_STS:   rd_mux = DW'({|idb_q, mst_q});
      K_MSK:   rd_mux = DW'(msk_q);
      K_SCR:   rd_mux = scr_flat[idx*DW +: DW];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign status_o = {|idb_q, mst_q};
  assign mask_o   = msk_q;
  assign indb_o   = idb_q;
endmodule

// File: rtl/xdom_mailbox.sv
module xdom_mailbox #(
  parameter int DW   = 32,
  parameter int AW   = 4,
  parameter int NMSG = 4,
  parameter int NSCR = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_wr_en,
  input  logic          a_rd_en,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_wr_en,
  input  logic          b_rd_en,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  localparam int STW = NMSG + 1;

  logic [NMSG-1:0]    a_msg_wr, b_msg_wr;
  logic [DW-1:0]      a_db_set, b_db_set;
  logic [NSCR-1:0]    a_scr_wr, b_scr_wr;
  logic [NSCR*DW-1:0] scr_flat;
  logic [STW-1:0]     a_status, b_status, a_mask, b_mask;
  logic [DW-1:0]      a_indb, b_indb;

  mbx_side_regs #(.DW(DW), .AW(AW), .NMSG(NMSG), .NSCR(NSCR)) u_side_a (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (a_wr_en),
    .rd_en         (a_rd_en),
    .addr          (a_addr),
    .wdata         (a_wdata),
    .rdata         (a_rdata),
    .irq           (a_irq),
    .peer_msg_wr   (b_msg_wr),
    .peer_msg_data (b_wdata),
    .peer_db_set   (b_db_set),
    .msg_wr_o      (a_msg_wr),
    .db_set_o      (a_db_set),
    .scr_wr_o      (a_scr_wr),
    .scr_flat      (scr_flat),
    .status_o      (a_status),
    .mask_o        (a_mask),
    .indb_o        (a_indb)
  );

  mbx_side_regs #(.DW(DW), .AW(AW), .NMSG(NMSG), .NSCR(NSCR)) u_side_b (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (b_wr_en),
    .rd_en         (b_rd_en),
    .addr          (b_addr),
    .wdata         (b_wdata),
    .rdata         (b_rdata),
    .irq           (b_irq),
    .peer_msg_wr   (a_msg_wr),
    .peer_msg_data (a_wdata),
    .peer_db_set   (a_db_set),
    .msg_wr_o      (b_msg_wr),
    .db_set_o      (b_db_set),
    .scr_wr_o      (b_scr_wr),
    .scr_flat      (scr_flat),
    .status_o      (b_status),
    .mask_o        (b_mask),
    .indb_o        (b_indb)
  );

  mbx_scratch #(.DW(DW), .NSCR(NSCR)) u_scr (
    .clk      (clk),
    .rst      (rst),
    .a_wr     (a_scr_wr),
    .b_wr     (b_scr_wr),
    .a_data   (a_wdata),
    .b_data   (b_wdata),
    .scr_flat (scr_flat)
  );
endmodule

// File: rtl/xdom_mailbox_chk.sv
module xdom_mailbox_chk #(
  parameter int DW   = 32,
  parameter int AW   = 4,
  parameter int NMSG = 4,
  parameter int NSCR = 2,
  localparam int STW = NMSG + 1,
  localparam int MIW = (NMSG > 1) ? $clog2(NMSG) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               a_wr_en,
  input logic [AW-1:0]      a_addr,
  input logic [DW-1:0]      a_wdata,
  input logic               b_wr_en,
  input logic [AW-1:0]      b_addr,
  input logic [DW-1:0]      b_wdata,
  input logic               a_irq,
  input logic [STW-1:0]     a_status,
  input logic [STW-1:0]     a_mask,
  input logic [DW-1:0]      a_indb,
  input logic [DW-1:0]      b_indb,
  input logic [NSCR*DW-1:0] scr_flat
);
  localparam logic [AW-1:0] ODB_A = AW'(2 * NMSG);
  localparam logic [AW-1:0] IDB_A = AW'(2 * NMSG + 1);
  localparam logic [AW-1:0] SCR_A = AW'(2 * NMSG + 4);

  // R3: a B-side outbound message write flags the matching A-side status bit
  p_msg_status_r3: assert property (@(posedge clk) disable iff (rst)
    (b_wr_en && (b_addr < AW'(NMSG))) |=> a_status[$past(b_addr[MIW-1:0])]);

  // R5: an A-side doorbell write shows up in B's inbound doorbell
  p_db_mirror_r5: assert property (@(posedge clk) disable iff (rst)
    (a_wr_en && (a_addr == ODB_A)) |=> ((b_indb & $past(a_wdata)) == $past(a_wdata)));

  // R9: interrupt line matches unmasked status
  p_irq_mask_r9: assert property (@(posedge clk) disable iff (rst)
    a_irq == |(a_status & ~a_mask));

  // R11: A wins a scratchpad collision
  p_scr_prio_r11: assert property (@(posedge clk) disable iff (rst)
    (a_wr_en && b_wr_en && (a_addr == SCR_A) && (b_addr == SCR_A))
      |=> (scr_flat[DW-1:0] == $past(a_wdata)));

  // R12: far-side set beats local clear on A's inbound doorbell
  p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
    (b_wr_en && (b_addr == ODB_A) && a_wr_en && (a_addr == IDB_A))
      |=> ((a_indb & $past(b_wdata)) == $past(b_wdata)));
endmodule

bind xdom_mailbox xdom_mailbox_chk #(.DW(DW), .AW(AW), .NMSG(NMSG), .NSCR(NSCR)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_wr_en  (a_wr_en),
  .a_addr   (a_addr),
  .a_wdata  (a_wdata),
  .b_wr_en  (b_wr_en),
  .b_addr   (b_addr),
  .b_wdata  (b_wdata),
  .a_irq    (a_irq),
  .a_status (a_status),
  .a_mask   (a_mask),
  .a_indb   (a_indb),
  .b_indb   (b_indb),
  .scr_flat (scr_flat)
);

// File: tb/xdom_mailbox_tb_top.sv
module xdom_mailbox_tb_top;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_wr_en = 0, a_rd_en = 0, b_wr_en = 0, b_rd_en = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_irq, b_irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xdom_mailbox #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst),
    .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  // entry: {side(1: 0=A,1=B), write(1), addr(4), data(32), req(4)}
  localparam int NV = 30;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'd0,  32'h1111_0000, 4'd2},  // R2 write A obm0
    {1'b0, 1'b0, 4'd0,  32'h1111_0000, 4'd2},  // R2 readback
    {1'b1, 1'b0, 4'd4,  32'h1111_0000, 4'd3},  // R3 B ibm0
    {1'b1, 1'b0, 4'd10, 32'h0000_0001, 4'd3},  // R3 B status bit0
    {1'b1, 1'b1, 4'd5,  32'h0000_DEAD, 4'd4},  // R4 write to inbound
    {1'b1, 1'b0, 4'd5,  32'h0000_0000, 4'd4},  // R4 unchanged
    {1'b1, 1'b1, 4'd10, 32'h0000_0001, 4'd8},  // R8 W1C bit0
    {1'b1, 1'b0, 4'd10, 32'h0000_0000, 4'd8},  // R8 cleared
    {1'b0, 1'b1, 4'd8,  32'h8000_0005, 4'd5},  // R5 ring
    {1'b1, 1'b0, 4'd9,  32'h8000_0005, 4'd5},  // R5 B inbound
    {1'b1, 1'b0, 4'd10, 32'h0000_0010, 4'd7},  // R7 summary set
    {1'b0, 1'b0, 4'd8,  32'h8000_0005, 4'd5},  // R5 outbound readback
    {1'b0, 1'b1, 4'd8,  32'h0000_0002, 4'd5},  // R5 ring more
    {1'b1, 1'b0, 4'd9,  32'h8000_0007, 4'd5},  // R5 accumulate
    {1'b1, 1'b1, 4'd9,  32'h8000_0004, 4'd6},  // R6 clear some
    {1'b1, 1'b0, 4'd9,  32'h0000_0003, 4'd6},  // R6 remaining
    {1'b1, 1'b1, 4'd10, 32'h0000_0010, 4'd7},  // R7 write bit4
    {1'b1, 1'b0, 4'd10, 32'h0000_0010, 4'd7},  // R7 still set
    {1'b1, 1'b1, 4'd9,  32'h0000_0003, 4'd6},  // R6 clear rest
    {1'b1, 1'b0, 4'd10, 32'h0000_0000, 4'd7},  // R7 summary drops
    {1'b1, 1'b1, 4'd12, 32'h0000_CAFE, 4'd10}, // R10 B scratch0
    {1'b0, 1'b0, 4'd12, 32'h0000_CAFE, 4'd10}, // R10 A sees it
    {1'b0, 1'b0, 4'd10, 32'h0000_0000, 4'd10}, // R10 no A status
    {1'b0, 1'b1, 4'd13, 32'h0000_1234, 4'd10}, // R10 A scratch1
    {1'b1, 1'b0, 4'd13, 32'h0000_1234, 4'd10}, // R10 B sees it
    {1'b1, 1'b0, 4'd10, 32'h0000_0000, 4'd10}, // R10 no B status
    {1'b0, 1'b1, 4'd11, 32'h0000_001F, 4'd9},  // R9 mask write
    {1'b0, 1'b0, 4'd11, 32'h0000_001F, 4'd9},  // R9 mask readback
    {1'b0, 1'b1, 4'd11, 32'h0000_0000, 4'd9},  // R9 unmask
    {1'b0, 1'b0, 4'd11, 32'h0000_0000, 4'd9}   // R9 mask readback
  };

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input bit side, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    @(negedge clk);
    if (side) begin b_wr_en = 1; b_addr = ad; b_wdata = d; end
    else      begin a_wr_en = 1; a_addr = ad; a_wdata = d; end
    @(posedge clk);
    @(negedge clk);
    a_wr_en = 0; b_wr_en = 0;
  endtask

  task automatic wr2(input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                     input logic [AW-1:0] ba, input logic [DW-1:0] bd);
    @(negedge clk);
    a_wr_en = 1; a_addr = aa; a_wdata = ad;
    b_wr_en = 1; b_addr = ba; b_wdata = bd;
    @(posedge clk);
    @(negedge clk);
    a_wr_en = 0; b_wr_en = 0;
  endtask

  task automatic rd(input bit side, input logic [AW-1:0] ad, output logic [DW-1:0] d);
    @(negedge clk);
    if (side) begin b_rd_en = 1; b_addr = ad; end
    else      begin a_rd_en = 1; a_addr = ad; end
    @(posedge clk);
    @(negedge clk);
    a_rd_en = 0; b_rd_en = 0;
    d = side ? b_rdata : a_rdata;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 a_irq", DW'(a_irq), 0);
    chk("R1 b_irq", DW'(b_irq), 0);
    rd(0, 4'd0, v);  chk("R1 A obm0", v, 0);
    rd(1, 4'd10, v); chk("R1 B status", v, 0);
    rd(1, 4'd12, v); chk("R1 scratch0", v, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) wr(VEC[i][41], VEC[i][39:36], VEC[i][35:4]);
      else begin
        rd(VEC[i][41], VEC[i][39:36], v);
        chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), v, VEC[i][35:4]);
      end
    end

    // R9 interrupt from message status, masking, clearing
    wr(1, 4'd2, 32'hABCD);
    chk("R9 a_irq raised", DW'(a_irq), 1);
    rd(0, 4'd10, v); chk("R3 A status bit2", v, 32'h4);
    rd(0, 4'd6, v);  chk("R3 A ibm2", v, 32'hABCD);
    wr(0, 4'd11, 32'h4);
    chk("R9 a_irq masked", DW'(a_irq), 0);
    wr(0, 4'd11, 32'h0);
    chk("R9 a_irq unmasked", DW'(a_irq), 1);
    wr(0, 4'd10, 32'h4);
    chk("R9 a_irq after W1C", DW'(a_irq), 0);

    // R11 scratch collision
    wr2(4'd12, 32'hAAAA_0001, 4'd12, 32'hBBBB_0002);
    rd(1, 4'd12, v); chk("R11 A wins", v, 32'hAAAA_0001);

    // R12 set beats clear: doorbell and message status on side B
    wr(0, 4'd8, 32'h1);
    wr2(4'd8, 32'h1, 4'd9, 32'h1);
    rd(1, 4'd9, v); chk("R12 doorbell set wins", v, 32'h1);
    wr(0, 4'd1, 32'h55);
    wr2(4'd1, 32'h66, 4'd10, 32'h2);
    rd(1, 4'd10, v); chk("R12 status set wins", v, 32'h12);
    wr(1, 4'd9, 32'hFFFF_FFFF);
    wr(1, 4'd10, 32'hF);
    chk("R12 b_irq cleared", DW'(b_irq), 0);

    // R13 handshake A -> B, acknowledge B -> A
    for (int k = 0; k < 4; k++) wr(0, AW'(k), 32'hC0DE_0000 + DW'(k));
    wr(1, 4'd10, 32'hF);
    chk("R13 no irq before ring", DW'(b_irq), 0);
    wr(0, 4'd8, 32'h1);
    chk("R13 b_irq on ring", DW'(b_irq), 1);
    rd(1, 4'd9, v); chk("R13 bit0 rung", v, 32'h1);
    for (int k = 0; k < 4; k++) begin
      rd(1, AW'(4 + k), v);
      chk($sformatf("R13 word %0d", k), v, 32'hC0DE_0000 + DW'(k));
    end
    wr(1, 4'd9, 32'h1);
    chk("R13 b_irq cleared", DW'(b_irq), 0);
    wr(1, 4'd8, 32'h2);
    chk("R13 a_irq on ack", DW'(a_irq), 1);
    rd(0, 4'd9, v); chk("R13 ack bit1", v, 32'h2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule